// File: doc/BRIEF.md
# Distributed Persistent Request Table

This block sits beside one cache controller in a multiprocessor that settles contention with persistent requests broadcast by every processor. It keeps one slot for each processor in the system, indexed by processor number. A slot holds a valid bit, the block address the processor is starving for, and whether it needs write or read permission. Activate messages fill a slot and deactivate messages empty it. Every cache keeps an identical copy and runs the same fixed-priority choice, so all caches agree on which processor is currently served for an address without any central arbiter.

The cache controller presents an address on the lookup port. In the same cycle it learns whether a persistent request covers that address and, if so, which processor wins and whether that processor wants to write. The local processor also asks the issue port whether it may launch a new persistent request for an address. After its own request for an address has been served, it is held back until every other request for that address that was pending at that moment has been retired. This keeps a fast local processor from cutting in ahead of the processors it just outranked.

Top module: `prt_table`

## Requirements
- R1: After reset every slot is empty, `lookup_hit` is 0, `proto_err` is 0 and `issue_allowed` is 1 for any address.
- R2: A message with `msg_valid`=1 and `msg_activate`=1 from source s, while slot s is empty, stores `msg_addr` and `msg_write` in slot s. The stored request is visible on the lookup port from the cycle after the clock edge.
- R3: A message with `msg_valid`=1 and `msg_activate`=0 from source s empties slot s at the clock edge. If slot s is already empty, the message leaves the table unchanged.
- R4: `lookup_hit` is combinational from `lookup_addr` and is 1 exactly when some valid slot holds that address.
- R5: When several valid slots hold the looked-up address, `lookup_winner` is the lowest processor number among them.
- R6: `lookup_write` is the write flag of the winning slot, where 1 means write and 0 means read.
- R7: An activate for a slot that is already valid drives `proto_err` high in the same cycle and leaves that slot's address and write flag unchanged.
- R8: Messages are applied one per cycle in arrival order. An activate followed in the next cycle by a deactivate from the same source leaves the slot empty. A deactivate followed by an activate leaves it filled.
- R9: When a deactivate from processor `LOCAL_ID` empties its valid slot while another valid slot holds the same address, the guard blocks that address. `issue_allowed` is then 0 for that address and stays 1 for any other address.
- R10: The block is released on the clock edge that follows the first cycle in which no valid slot holds the blocked address. `issue_allowed` is therefore still 0 in the cycle right after the last matching slot empties.
- R11: A local deactivate when no other valid slot holds the same address does not block, so `issue_allowed` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_valid | input | 1 | An incoming persistent-request message is present |
| msg_activate | input | 1 | 1 = activate, 0 = deactivate |
| msg_src | input | ID_W | Processor that sent the message |
| msg_addr | input | ADDR_W | Block address carried by the message |
| msg_write | input | 1 | 1 = write request, 0 = read request (activate only) |
| lookup_addr | input | ADDR_W | Address searched in the table |
| lookup_hit | output | 1 | A valid slot holds `lookup_addr` |
| lookup_winner | output | ID_W | Lowest processor number among matching slots |
| lookup_write | output | 1 | Write flag of the winning slot |
| proto_err | output | 1 | Activate received for an already valid slot |
| issue_addr | input | ADDR_W | Address the local processor wants to request |
| issue_allowed | output | 1 | The local processor may issue a persistent request for `issue_addr` |

## Verification
On every cycle the assertions check that each slot fills, empties or holds exactly as the message on the bus dictates. They also check that a reported winner really holds the address and has no lower-numbered valid match, and that the blocking flag rises only on a local retirement with rivals present and drops once the address has drained. Only the bench's scenarios can show the agreement of lookup answers with an independently kept table across all sixteen occupancy patterns. They also show the exact cycle in which the issue port reopens, and the effect of back-to-back opposite messages from one source.

// File: rtl/prt_pkg.sv
// Package prt_pkg
// Shared message encoding for the persistent request table.
// Assumes one message per cycle on the incoming message bus.
package prt_pkg;
    typedef enum logic {
        MSG_DEACT = 1'b0,
        MSG_ACT   = 1'b1
    } msg_kind_e;
endpackage

// File: rtl/prt_entry.sv
// Module prt_entry
// One slot of the table, owned by processor IDX. It fills on an activate
// from its owner while empty and empties on a deactivate from its owner.
// It flags an activate that arrives while it is already full and ignores it.
// Assumes msg_* are meaningful only while msg_valid is high.
module prt_entry
    import prt_pkg::*;
#(
    parameter int NPROC  = 4,
    parameter int ADDR_W = 8,
    parameter int IDX    = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     msg_valid,
    input  msg_kind_e                msg_kind,
    input  logic [$clog2(NPROC)-1:0] msg_src,
    input  logic [ADDR_W-1:0]        msg_addr,
    input  logic                     msg_write,
    output logic                     valid,
    output logic [ADDR_W-1:0]        addr,
    output logic                     write,
    output logic                     act_conflict
);
    localparam int ID_W = $clog2(NPROC);
    localparam logic [ID_W-1:0] MY_ID = ID_W'(IDX);

    logic sel;

    // Message addressed to this slot
    assign sel          = msg_valid && (msg_src == MY_ID);
    // Activate while already occupied is a protocol error
    assign act_conflict = sel && (msg_kind == MSG_ACT) && valid;

    // Slot state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            addr  <= '0;
            write <= 1'b0;
        end else if (sel) begin
            if (msg_kind == MSG_ACT && !valid) begin
                valid <= 1'b1;
                addr  <= msg_addr;
                write <= msg_write;
            end else if (msg_kind == MSG_DEACT) begin
                valid <= 1'b0;
            end
        end
    end

    a_r2_activate_stores: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && msg_kind == MSG_ACT && !valid) |=>
            (valid && addr == $past(msg_addr) && write == $past(msg_write)));

    a_r3_deactivate_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && msg_kind == MSG_DEACT) |=> !valid);

    a_r3_no_spurious_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !(sel && msg_kind == MSG_ACT)) |=> !valid);

    a_r7_conflict_keeps_slot: assert property (@(posedge clk) disable iff (!rst_n)
        act_conflict |=> (valid && $stable(addr) && $stable(write)));
endmodule

// File: rtl/prt_match_arb.sv
// Module prt_match_arb
// Associative search of all slots for one query address, with fixed
// priority: the lowest processor number among matching slots wins.
// Slots flagged in excl are left out of the search. Purely combinational;
// the clock is used only by the embedded checks.
module prt_match_arb #(
    parameter int NPROC  = 4,
    parameter int ADDR_W = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NPROC-1:0]                   valid,
    input  logic [NPROC-1:0][ADDR_W-1:0]       addr,
    input  logic [NPROC-1:0]                   write,
    input  logic [NPROC-1:0]                   excl,
    input  logic [ADDR_W-1:0]                  query,
    output logic                               hit,
    output logic [$clog2(NPROC)-1:0]           winner,
    output logic                               win_write
);
    localparam int ID_W = $clog2(NPROC);

    logic [NPROC-1:0] match;

    // Per-slot address compare
    genvar g;
    generate
        for (g = 0; g < NPROC; g++) begin : g_cmp
            assign match[g] = valid[g] && !excl[g] && (addr[g] == query);
        end
    endgenerate

    // Priority pick, scanning high to low so the lowest index is kept
    always_comb begin
        hit       = 1'b0;
        winner    = '0;
        win_write = 1'b0;
        for (int i = NPROC - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit       = 1'b1;
                winner    = ID_W'(i);
                win_write = write[i];
            end
        end
    end

    a_r4_hit_is_real: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (valid[winner] && !excl[winner] && addr[winner] == query));

    generate
        for (g = 0; g < NPROC; g++) begin : g_chk
            a_r5_no_lower_match: assert property (@(posedge clk) disable iff (!rst_n)
                (hit && winner > ID_W'(g)) |->
                    !(valid[g] && !excl[g] && addr[g] == query));
            a_r4_miss_is_empty: assert property (@(posedge clk) disable iff (!rst_n)
                !hit |-> !(valid[g] && !excl[g] && addr[g] == query));
        end
    endgenerate
endmodule

// File: rtl/prt_wave_guard.sv
// Module prt_wave_guard
// Holds back the local processor after its persistent request is retired
// while rivals for the same address are still pending. The hold is lifted
// once the table holds no valid slot for that address.
// Assumes others_match is computed on the slots before the retiring edge.
module prt_wave_guard #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              local_done,
    input  logic [ADDR_W-1:0] done_addr,
    input  logic              others_match,
    input  logic              drain_hit,
    input  logic [ADDR_W-1:0] issue_addr,
    output logic              blocked,
    output logic [ADDR_W-1:0] blocked_addr,
    output logic              issue_allowed
);
    logic arm;

    // Local retirement with rivals still queued on the same address
    assign arm = local_done && others_match;

    // Blocking flag and the address it guards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blocked      <= 1'b0;
            blocked_addr <= '0;
        end else if (arm) begin
            blocked      <= 1'b1;
            blocked_addr <= done_addr;
        end else if (blocked && !drain_hit) begin
            blocked <= 1'b0;
        end
    end

    // Issue permission for the requested address
    assign issue_allowed = !(blocked && (issue_addr == blocked_addr));

    a_r9_block_needs_rivals: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blocked) |-> $past(local_done && others_match));

    a_r10_release_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && !drain_hit && !arm) |=> !blocked);

    a_r10_hold_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && drain_hit) |=> (blocked && $stable(blocked_addr)));
endmodule

// File: rtl/prt_table.sv
// Module prt_table
// Per-cache persistent request table: one slot per processor, fed by
// broadcast activate/deactivate messages, searched by address with
// lowest-number priority, plus the local reissue guard.
// Assumes messages from one source arrive in order, one per cycle overall.
module prt_table
    import prt_pkg::*;
#(
    parameter int NPROC    = 4,
    parameter int ADDR_W   = 8,
    parameter int LOCAL_ID = 0,
    localparam int ID_W    = $clog2(NPROC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic              msg_activate,
    input  logic [ID_W-1:0]   msg_src,
    input  logic [ADDR_W-1:0] msg_addr,
    input  logic              msg_write,
    input  logic [ADDR_W-1:0] lookup_addr,
    output logic              lookup_hit,
    output logic [ID_W-1:0]   lookup_winner,
    output logic              lookup_write,
    output logic              proto_err,
    input  logic [ADDR_W-1:0] issue_addr,
    output logic              issue_allowed
);
    localparam logic [ID_W-1:0] LOC = ID_W'(LOCAL_ID);
    localparam logic [NPROC-1:0] EXCL_NONE  = '0;
    localparam logic [NPROC-1:0] EXCL_LOCAL = NPROC'(1) << LOCAL_ID;

    msg_kind_e                   kind;
    logic [NPROC-1:0]            ent_valid;
    logic [NPROC-1:0][ADDR_W-1:0] ent_addr;
    logic [NPROC-1:0]            ent_write;
    logic [NPROC-1:0]            conflict;
    logic                        local_done;
    logic                        others_hit;
    logic [ID_W-1:0]             others_id;
    logic                        others_wr;
    logic                        drain_hit;
    logic [ID_W-1:0]             drain_id;
    logic                        drain_wr;
    logic                        blocked;
    logic [ADDR_W-1:0]           blocked_addr;

    // Decode the message kind
    assign kind = msg_activate ? MSG_ACT : MSG_DEACT;

    genvar g;
    generate
        for (g = 0; g < NPROC; g++) begin : g_slot
            prt_entry #(.NPROC(NPROC), .ADDR_W(ADDR_W), .IDX(g)) u_entry (
                .clk          (clk),
                .rst_n        (rst_n),
                .msg_valid    (msg_valid),
                .msg_kind     (kind),
                .msg_src      (msg_src),
                .msg_addr     (msg_addr),
                .msg_write    (msg_write),
                .valid        (ent_valid[g]),
                .addr         (ent_addr[g]),
                .write        (ent_write[g]),
                .act_conflict (conflict[g])
            );
        end
    endgenerate

    // Any slot reporting a double activate
    assign proto_err = |conflict;

    // Lookup port search
    prt_match_arb #(.NPROC(NPROC), .ADDR_W(ADDR_W)) u_lookup (
        .clk (clk), .rst_n (rst_n),
        .valid (ent_valid), .addr (ent_addr), .write (ent_write),
        .excl (EXCL_NONE), .query (lookup_addr),
        .hit (lookup_hit), .winner (lookup_winner), .win_write (lookup_write)
    );

    // Rivals of the local slot on its own address
    prt_match_arb #(.NPROC(NPROC), .ADDR_W(ADDR_W)) u_rivals (
        .clk (clk), .rst_n (rst_n),
        .valid (ent_valid), .addr (ent_addr), .write (ent_write),
        .excl (EXCL_LOCAL), .query (ent_addr[LOCAL_ID]),
        .hit (others_hit), .winner (others_id), .win_write (others_wr)
    );

    // Any slot still holding the blocked address
    prt_match_arb #(.NPROC(NPROC), .ADDR_W(ADDR_W)) u_drain (
        .clk (clk), .rst_n (rst_n),
        .valid (ent_valid), .addr (ent_addr), .write (ent_write),
        .excl (EXCL_NONE), .query (blocked_addr),
        .hit (drain_hit), .winner (drain_id), .win_write (drain_wr)
    );

    // Local processor retires its valid persistent request
    assign local_done = msg_valid && (kind == MSG_DEACT) && (msg_src == LOC)
                        && ent_valid[LOCAL_ID];

    prt_wave_guard #(.ADDR_W(ADDR_W)) u_guard (
        .clk           (clk),
        .rst_n         (rst_n),
        .local_done    (local_done),
        .done_addr     (ent_addr[LOCAL_ID]),
        .others_match  (others_hit),
        .drain_hit     (drain_hit),
        .issue_addr    (issue_addr),
        .blocked       (blocked),
        .blocked_addr  (blocked_addr),
        .issue_allowed (issue_allowed)
    );

    a_r1_reset_empty: assert property (@(posedge clk)
        $past(!rst_n) |-> (ent_valid == '0 && !blocked));

    a_r9_rival_id_real: assert property (@(posedge clk) disable iff (!rst_n)
        others_hit |-> (others_id != LOC && ent_valid[others_id]
                        && ent_write[others_id] == others_wr));

    a_r10_drain_id_real: assert property (@(posedge clk) disable iff (!rst_n)
        drain_hit |-> (ent_addr[drain_id] == blocked_addr
                       && ent_write[drain_id] == drain_wr));
endmodule

// File: tb/tb_prt_table.sv
module tb_prt_table;
    localparam int CLK_PERIOD = 10;
    localparam int NPROC  = 4;
    localparam int ADDR_W = 8;
    localparam int ID_W   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              msg_valid = 1'b0;
    logic              msg_activate = 1'b0;
    logic [ID_W-1:0]   msg_src = '0;
    logic [ADDR_W-1:0] msg_addr = '0;
    logic              msg_write = 1'b0;
    logic [ADDR_W-1:0] lookup_addr = '0;
    logic              lookup_hit;
    logic [ID_W-1:0]   lookup_winner;
    logic              lookup_write;
    logic              proto_err;
    logic [ADDR_W-1:0] issue_addr = '0;
    logic              issue_allowed;

    int total = 0;
    int bad = 0;
    bit done = 0;

    bit          mv [NPROC];
    logic [7:0]  ma [NPROC];
    bit          mw [NPROC];

    always #(CLK_PERIOD / 2) clk = ~clk;

    prt_table #(.NPROC(NPROC), .ADDR_W(ADDR_W), .LOCAL_ID(0)) dut (
        .clk (clk), .rst_n (rst_n),
        .msg_valid (msg_valid), .msg_activate (msg_activate),
        .msg_src (msg_src), .msg_addr (msg_addr), .msg_write (msg_write),
        .lookup_addr (lookup_addr), .lookup_hit (lookup_hit),
        .lookup_winner (lookup_winner), .lookup_write (lookup_write),
        .proto_err (proto_err),
        .issue_addr (issue_addr), .issue_allowed (issue_allowed)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Send one message; checks the same-cycle error flag, then updates the model
    task automatic send(input bit act, input int src, input logic [7:0] a, input bit wr);
        bit exp_err;
        @(negedge clk);
        msg_valid = 1'b1; msg_activate = act; msg_src = ID_W'(src);
        msg_addr = a; msg_write = wr;
        #1;
        exp_err = act && mv[src];
        chk(proto_err == exp_err, "R7 proto_err", proto_err, exp_err);
        @(posedge clk);
        #1 msg_valid = 1'b0;
        if (act && !mv[src]) begin mv[src] = 1; ma[src] = a; mw[src] = wr; end
        else if (!act) mv[src] = 0;
    endtask

    // Compare the lookup port against the model
    task automatic look(input logic [7:0] q, input string tag);
        bit eh; int ew; bit ewr;
        @(negedge clk);
        lookup_addr = q;
        #1;
        eh = 0; ew = 0; ewr = 0;
        for (int i = NPROC - 1; i >= 0; i--)
            if (mv[i] && ma[i] == q) begin eh = 1; ew = i; ewr = mw[i]; end
        chk(lookup_hit == eh, {tag, " R4 hit"}, lookup_hit, eh);
        if (eh) begin
            chk(int'(lookup_winner) == ew, {tag, " R5 winner"}, lookup_winner, ew);
            chk(lookup_write == ewr, {tag, " R6 write"}, lookup_write, ewr);
        end
    endtask

    task automatic issue(input logic [7:0] a, input bit exp, input string tag);
        @(negedge clk);
        issue_addr = a;
        #1 chk(issue_allowed == exp, tag, issue_allowed, exp);
    endtask

    initial begin
        for (int i = 0; i < NPROC; i++) begin mv[i] = 0; ma[i] = 0; mw[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        chk(lookup_hit == 0, "R1 hit after reset", lookup_hit, 0);
        chk(proto_err == 0, "R1 err after reset", proto_err, 0);
        chk(issue_allowed == 1, "R1 issue after reset", issue_allowed, 1);

        // R2 R4 R5 R6 R3: every occupancy pattern of the four slots
        for (int m = 0; m < 16; m++) begin
            for (int i = 0; i < NPROC; i++)
                if (m[i]) send(1, i, (i < 2) ? 8'h10 : 8'h11, (i == 1 || i == 2));
            look(8'h10, "R2 sweep");
            look(8'h11, "R2 sweep");
            look(8'h12, "R4 sweep absent");
            for (int i = 0; i < NPROC; i++)
                if (m[i]) send(0, i, (i < 2) ? 8'h10 : 8'h11, 0);
            look(8'h10, "R3 sweep cleared");
            look(8'h11, "R3 sweep cleared");
        end
        repeat (2) @(negedge clk);

        // R7: double activate leaves slot unchanged
        send(1, 2, 8'h50, 1);
        send(1, 2, 8'h51, 0);
        look(8'h50, "R7 kept");
        look(8'h51, "R7 ignored");
        send(0, 2, 8'h50, 0);
        // R3: deactivate of an empty slot changes nothing
        send(1, 3, 8'h52, 0);
        send(0, 1, 8'h52, 0);
        look(8'h52, "R3 empty deact");
        send(0, 3, 8'h52, 0);

        // R8: back-to-back opposite messages from one source
        send(1, 2, 8'h60, 1);
        send(0, 2, 8'h60, 0);
        look(8'h60, "R8 act then deact");
        send(0, 1, 8'h61, 0);
        send(1, 1, 8'h61, 0);
        look(8'h61, "R8 deact then act");
        send(0, 1, 8'h61, 0);

        // R11: local retirement alone does not block
        send(1, 0, 8'h40, 1);
        send(0, 0, 8'h40, 0);
        issue(8'h40, 1, "R11 no rivals");

        // R9 R10: wave rule
        send(1, 0, 8'h20, 1);
        send(1, 2, 8'h20, 0);
        send(1, 3, 8'h20, 1);
        send(1, 1, 8'h30, 0);
        send(0, 0, 8'h20, 0);
        issue(8'h20, 0, "R9 blocked addr");
        issue(8'h30, 1, "R9 other addr open");
        send(0, 2, 8'h20, 0);
        issue(8'h20, 0, "R9 still pending");
        send(0, 3, 8'h20, 0);
        chk(issue_allowed == 0, "R10 one cycle after drain", issue_allowed, 0);
        @(posedge clk);
        issue(8'h20, 1, "R10 released");
        send(0, 1, 8'h30, 0);
        issue(8'h30, 1, "R10 unrelated");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule